// File: doc/BRIEF.md
# Masked-Access GPIO Port

An eight-pin general-purpose I/O port on a simple byte-wide register bus. Each pin has a direction bit. The port drives an output-enable vector and an output-value vector toward the pad ring. Pad inputs pass through a two-flop synchronizer before any use. The data register occupies a whole address window. In that window, word-address bits pick the pins that a write may change and the bits that a read returns. Software can therefore flip any subset of pins with one store and no read-modify-write.

The same port carries the interrupt setup for each pin: level or edge sense, both-edge selection, active polarity and enable. It also gives a raw status view, a masked status view and a write-one-to-clear register. A separate event unit inside the block turns the synchronized pins into status bits. A single registered interrupt line reports any enabled event.

A read is issued with `bus_rd`. `bus_rdata` holds the result from the following clock edge until the next read. A write takes effect on the edge where `bus_wr` is high. Address bits [1:0] are ignored.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pad_oe`, `pad_out`, `irq` and `bus_rdata` are 0. Reads of direction (0x400), sense (0x404), both-edge (0x408), polarity (0x40C) and enable (0x410) return 0 after reset.
- R2: A write to an offset below 0x400 changes only those output pins n whose address bit n+2 is 1. All other output bits of `pad_out` keep their value.
- R3: A data write never changes `pad_out` bit n while direction bit n is 0. The stored value for such a pin stays in place, so it appears on `pad_out` unchanged once the pin becomes an output.
- R4: The direction register at 0x400 reads back as written and drives `pad_oe` directly. A bit value of 1 makes the pin an output.
- R5: A read below 0x400 returns 0 in every bit whose address mask bit is 0. A selected bit returns the output register for an output pin and the synchronized pad level for an input pin.
- R6: A pad change is seen by a data read only after two clock edges. If `bus_rd` is held from the edge after the change, the read results of the first two edges still show the old level, and the result of the third edge shows the new level.
- R7: Sense (0x404), both-edge (0x408), polarity (0x40C) and enable (0x410) are 8-bit read/write registers, with bit n belonging to pin n.
- R8: A pin with sense bit 1 is level-triggered. Its raw status bit (0x414) follows whether the synchronized pin equals its polarity bit (1 = active high). Writing the clear register does not remove it while the level stays active.
- R9: A pin with sense bit 0 is edge-triggered. With both-edge bit 0, polarity 1 selects rising edges and polarity 0 selects falling edges. The raw status bit stays set until a 1 is written to that bit of the clear register at 0x41C. Other bits of the clear register leave their own pins alone.
- R10: With sense bit 0 and both-edge bit 1, either edge sets the raw status bit, whatever the polarity bit holds.
- R11: Masked status (0x418) reads raw status AND enable. `irq` is high exactly when masked status is nonzero, one cycle later.
- R12: Reads from 0x41C and from unmapped offsets return 0. Writes to 0x414, 0x418 and unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Output enable per pin |
| pad_out | output | 8 | Output value per pin |
| irq | output | 1 | Combined enabled event, registered |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before the first bus access. They also assume that `bus_wr` and `bus_rd` are never high together, and that the pad level is 0 while reset is applied, so that the edge detector does not see a false first edge. The bench drives every bus strobe for exactly one cycle from the falling clock edge and never overlaps the two strobes. It holds `pad_in` at 0 through reset and changes pads only at falling edges. It then waits several cycles before it reads any status that depends on the pads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word index inside the control page; offset = 0x400 + 4*index
  typedef enum logic [2:0] {
    CI_DIR   = 3'd0,
    CI_SENSE = 3'd1,
    CI_BOTH  = 3'd2,
    CI_POL   = 3'd3,
    CI_IEN   = 3'd4,
    CI_RAW   = 3'd5,
    CI_MSK   = 3'd6,
    CI_CLR   = 3'd7
  } ctl_idx_e;

  localparam int CTL_IDX_W = 3;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] raw_q;
  logic [W-1:0] ev_hit;
  logic [W-1:0] lv_hit;
  logic [W-1:0] raw_next;

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall;
    assign rise      = pin_i[g] & ~prev_q[g];
    assign fall      = ~pin_i[g] & prev_q[g];
    assign ev_hit[g] = both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall);
    assign lv_hit[g] = ~(pin_i[g] ^ pol_i[g]);
    assign raw_next[g] = lvl_i[g] ? lv_hit[g]
                                  : ((raw_q[g] & ~clr_i[g]) | ev_hit[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= pin_i;
      raw_q  <= raw_next;
    end
  end

  assign raw_o = raw_q;

  // edge-mode status never drops without a clear
  p_edge_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(raw_q) & ~$past(lvl_i) & ~$past(clr_i)) & ~raw_q) == '0))
    else $error("edge status dropped without clear");

  // level-mode status follows the pin one edge later, clear or not
  p_level_track_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((raw_q ^ ~($past(pin_i) ^ $past(pol_i))) & $past(lvl_i)) == '0))
    else $error("level status not following pin");
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic              irq
);
  localparam int MASK_LO  = 2;
  localparam int MASK_HI  = N_PINS + 1;
  localparam int PAGE_LSB = N_PINS + 2;
  localparam int UPPER_W  = ADDR_W - PAGE_LSB;
  localparam int IDX_HI   = MASK_LO + CTL_IDX_W - 1;

  // ---------------- decode ----------------
  logic              in_data, in_ctl;
  logic [N_PINS-1:0] sel_mask;
  ctl_idx_e          idx;
  logic              addr_lsb_unused;

  assign addr_lsb_unused = ^bus_addr[1:0];
  assign in_data  = (bus_addr[ADDR_W-1:PAGE_LSB] == '0);
  assign in_ctl   = (bus_addr[ADDR_W-1:PAGE_LSB] == UPPER_W'(1)) &&
                    (bus_addr[PAGE_LSB-1:IDX_HI+1] == '0);
  assign sel_mask = bus_addr[MASK_HI:MASK_LO];
  assign idx      = ctl_idx_e'(bus_addr[IDX_HI:MASK_LO]);

  // ---------------- state ----------------
  logic [N_PINS-1:0] dir_q, out_q, sense_q, both_q, pol_q, ien_q;
  logic [N_PINS-1:0] rdata_q, rd_next;
  logic              irq_q;
  logic [N_PINS-1:0] pin_s, raw_s, clr_vec, upd_mask;
  logic              wr_data, wr_ctl;

  assign wr_data  = bus_wr & in_data;
  assign wr_ctl   = bus_wr & in_ctl;
  assign upd_mask = sel_mask & dir_q;
  assign clr_vec  = (wr_ctl && idx == CI_CLR) ? bus_wdata : '0;

  gpio_in_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_s)
  );

  gpio_evt #(.W(N_PINS)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_s),
    .lvl_i  (sense_q),
    .both_i (both_q),
    .pol_i  (pol_q),
    .clr_i  (clr_vec),
    .raw_o  (raw_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      out_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
    end else begin
      if (wr_data) out_q <= (out_q & ~upd_mask) | (bus_wdata & upd_mask);
      if (wr_ctl) begin
        case (idx)
          CI_DIR:   dir_q   <= bus_wdata;
          CI_SENSE: sense_q <= bus_wdata;
          CI_BOTH:  both_q  <= bus_wdata;
          CI_POL:   pol_q   <= bus_wdata;
          CI_IEN:   ien_q   <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    rd_next = '0;
    if (in_data) begin
      rd_next = sel_mask & ((dir_q & out_q) | (~dir_q & pin_s));
    end else if (in_ctl) begin
      case (idx)
        CI_DIR:   rd_next = dir_q;
        CI_SENSE: rd_next = sense_q;
        CI_BOTH:  rd_next = both_q;
        CI_POL:   rd_next = pol_q;
        CI_IEN:   rd_next = ien_q;
        CI_RAW:   rd_next = raw_s;
        CI_MSK:   rd_next = raw_s & ien_q;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_next;
      irq_q <= |(raw_s & ien_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_oe    = dir_q;
  assign pad_out   = out_q;
  assign irq       = irq_q;

  // ---------------- assertions ----------------
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && in_data) |=> $stable(pad_out))
    else $error("pad_out moved without a data write");

  p_mask_only_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_data) |=> (((pad_out ^ $past(pad_out)) & ~$past(sel_mask)) == '0))
    else $error("unselected pin changed");

  p_input_hold_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0))
    else $error("input pin output value changed");

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_data && !in_ctl) |=> (bus_rdata == '0))
    else $error("unmapped read not zero");

  p_irq_off_r11: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq)
    else $error("irq with all enables clear");
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_oe, pad_out;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
  );

  // op[26:24] addr[23:12] data[11:4] req[3:0]
  // op: 0 write, 1 read+check, 2 set pads, 3 check pad_out, 4 check pad_oe
  localparam int NV = 24;
  localparam logic [26:0] TBL [NV] = '{
    {3'd2, 12'h000, 8'h5A, 4'd0},
    {3'd0, 12'h400, 8'h0F, 4'd0},
    {3'd0, 12'h3FC, 8'hFF, 4'd0},
    {3'd4, 12'h000, 8'h0F, 4'd4},   // R4 oe follows direction
    {3'd3, 12'h000, 8'h0F, 4'd2},   // R2 full mask, inputs untouched
    {3'd1, 12'h400, 8'h0F, 4'd4},   // R4 readback
    {3'd1, 12'h3FC, 8'h5F, 4'd5},   // R5 outputs mixed with pads
    {3'd0, 12'h00C, 8'h00, 4'd0},
    {3'd3, 12'h000, 8'h0C, 4'd2},   // R2 only pins 0,1 cleared
    {3'd1, 12'h3FC, 8'h5C, 4'd2},   // R2
    {3'd1, 12'h030, 8'h0C, 4'd5},   // R5 unselected bits zero
    {3'd1, 12'h300, 8'h40, 4'd5},   // R5 input pins from pads
    {3'd0, 12'h404, 8'h3C, 4'd0},
    {3'd1, 12'h404, 8'h3C, 4'd7},   // R7
    {3'd0, 12'h408, 8'hC3, 4'd0},
    {3'd1, 12'h408, 8'hC3, 4'd7},   // R7
    {3'd0, 12'h40C, 8'h81, 4'd0},
    {3'd1, 12'h40C, 8'h81, 4'd7},   // R7
    {3'd0, 12'h410, 8'h5A, 4'd0},
    {3'd1, 12'h410, 8'h5A, 4'd7},   // R7
    {3'd1, 12'h41C, 8'h00, 4'd12},  // R12 write-only reads zero
    {3'd1, 12'h800, 8'h00, 4'd12},  // R12 unmapped reads zero
    {3'd0, 12'h820, 8'hFF, 4'd0},
    {3'd1, 12'h400, 8'h0F, 4'd12}   // R12 unmapped write ignored
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pads(input logic [7:0] v);
    @(negedge clk); pad_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    for (int k = 0; k < 5; k++) rdchk("R1 config reg", 12'h400 + 12'(4*k), 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [11:0] a;
      logic [7:0]  d;
      string       tg;
      op = TBL[i][26:24]; a = TBL[i][23:12]; d = TBL[i][11:4];
      tg = $sformatf("R%0d vec%0d", TBL[i][3:0], i);
      case (op)
        3'd0: wr(a, d);
        3'd1: rdchk(tg, a, d);
        3'd2: pads(d);
        3'd3: begin @(negedge clk); check(tg, pad_out, d); end
        default: begin @(negedge clk); check(tg, pad_oe, d); end
      endcase
    end

    // R3 writes to input pins
    wr(12'h400, 8'h00);
    wr(12'h3FC, 8'hF0);
    @(negedge clk); check("R3 pad_out held", pad_out, 8'h0C);
    wr(12'h400, 8'hFF);
    @(negedge clk); check("R3 value after turning output", pad_out, 8'h0C);
    rdchk("R3 readback", 12'h3FC, 8'h0C);
    wr(12'h400, 8'h00);

    // R6 two-stage latency
    pads(8'h00);
    @(negedge clk); pad_in = 8'hFF; bus_rd = 1'b1; bus_addr = 12'h3FC;
    @(negedge clk); check("R6 edge1 old", bus_rdata, 8'h00);
    @(negedge clk); check("R6 edge2 old", bus_rdata, 8'h00);
    @(negedge clk); check("R6 edge3 new", bus_rdata, 8'hFF);
    bus_rd = 1'b0;

    // interrupt baseline
    wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h40C, 8'h00); wr(12'h410, 8'h00);
    pads(8'h00);
    wr(12'h41C, 8'hFF);
    rdchk("R9 cleared baseline", 12'h414, 8'h00);

    // R8 level
    wr(12'h40C, 8'h01); wr(12'h404, 8'h03);
    rdchk("R8 low-active pin", 12'h414, 8'h02);
    wr(12'h41C, 8'hFF);
    rdchk("R8 clear ignored", 12'h414, 8'h02);
    pads(8'h01);
    rdchk("R8 both active", 12'h414, 8'h03);
    pads(8'h02);
    rdchk("R8 both inactive", 12'h414, 8'h00);

    // R9 edges
    wr(12'h404, 8'h00);
    wr(12'h41C, 8'hFF);
    pads(8'h01);
    rdchk("R9 rise and fall", 12'h414, 8'h03);
    pads(8'h00);
    rdchk("R9 sticky", 12'h414, 8'h03);
    wr(12'h41C, 8'h01);
    rdchk("R9 selective clear", 12'h414, 8'h02);
    wr(12'h41C, 8'hFF);
    rdchk("R9 full clear", 12'h414, 8'h00);

    // R10 both edges
    wr(12'h408, 8'h04);
    pads(8'h04);
    rdchk("R10 rising seen", 12'h414, 8'h04);
    wr(12'h41C, 8'h04);
    rdchk("R10 cleared", 12'h414, 8'h00);
    pads(8'h00);
    rdchk("R10 falling seen", 12'h414, 8'h04);

    // R11 masking and irq
    wr(12'h410, 8'h04);
    rdchk("R11 masked", 12'h418, 8'h04);
    check("R11 irq high", {7'd0, irq}, 8'h01);
    wr(12'h410, 8'h00);
    rdchk("R11 masked off", 12'h418, 8'h00);
    check("R11 irq low", {7'd0, irq}, 8'h00);
    wr(12'h410, 8'h04);
    wr(12'h41C, 8'h04);
    rdchk("R11 after clear", 12'h418, 8'h00);
    check("R11 irq cleared", {7'd0, irq}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule